// File: doc/BRIEF.md
# Tag Challenge/Response Command Buffer

This block sits on the tag side between the command decoder and the encryption engine. The reader delivers an 80-bit challenge as five separate 16-bit word writes, each carrying a word index. When the last missing word arrives, the buffer hands the assembled challenge to the engine and starts it with a one-cycle pulse. No separate start command exists.

The engine returns the ciphertext one byte at a time, least significant byte first. The buffer packs the bytes in pairs into 16-bit words and keeps a count of completed words. Block-read commands name a start word offset and a word count. The buffer streams the requested words in ascending order. When a word has not been produced yet, the stream holds until the engine delivers it. A read can therefore be issued at once after the challenge and run alongside encryption.

A challenge write always begins a new cycle: it clears the completed-word count and cancels any read in progress. If it lands while encryption is running, it also aborts the engine.

Top module: `chal_resp_buf`

## Requirements
- R1: After reset, `rd_busy`, `rd_valid`, `rd_err`, `ct_ready`, `eng_start` and `eng_abort` are all 0.
- R2: A write with `chal_idx` i in 0..4 stores `chal_data` into `eng_chal[16*i+15:16*i]`. Writes with index 5, 6 or 7 change nothing and count toward no start.
- R3: `eng_start` is high for exactly one cycle, in the cycle after the write that completes all five challenge words written since reset or since the last start.
- R4: Engine bytes are packed in arrival order. Byte 2j forms bits [7:0] of ciphertext word j and byte 2j+1 forms bits [15:8].
- R5: An accepted read presents words offset, offset+1, and so on, each for one cycle with `rd_valid` high. A word is presented only after it is complete. Until then `rd_valid` stays low and `rd_busy` stays high.
- R6: A request with count 0, or with offset+count greater than 138, is rejected. `rd_err` pulses for one cycle after the request, `rd_busy` stays low and no data is presented.
- R7: A read of all 138 words issued right after the engine starts returns the full ciphertext correctly while encryption is still in progress.
- R8: A challenge write during encryption pulses `eng_abort` for one cycle in the next cycle and clears the completed-word count. Any challenge write cancels an active read. The engine restarts only once all five words have been written again.
- R9: A read request that arrives while `rd_busy` is high is ignored. It does not change the active stream and does not raise `rd_err`.
- R10: `ct_ready` goes high once all 138 words are complete and drops at the next challenge write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chal_wr | input | 1 | Challenge word write strobe |
| chal_idx | input | 3 | Challenge word index |
| chal_data | input | 16 | Challenge word value |
| rd_req | input | 1 | Block-read request strobe |
| rd_offset | input | 8 | First word of the read |
| rd_count | input | 8 | Number of words to read |
| rd_busy | output | 1 | A read stream is active |
| rd_err | output | 1 | One-cycle reject pulse |
| rd_valid | output | 1 | `rd_data` carries the next word |
| rd_data | output | 16 | Ciphertext word |
| ct_ready | output | 1 | All ciphertext words complete |
| eng_chal | output | 80 | Assembled challenge to the engine |
| eng_start | output | 1 | Engine start pulse |
| eng_abort | output | 1 | Engine abort pulse |
| eng_byte_valid | input | 1 | Engine byte strobe |
| eng_byte | input | 8 | Engine ciphertext byte |

## Verification
Some properties are checked on every cycle: the start and abort strobes are single pulses, an abort always coincides with an empty completed-word count, the count never exceeds 138 and never grows by more than one per cycle, and an active stream never addresses past the end of the ciphertext. The remaining behaviours can only be shown by the bench's scenarios: the word contents and byte order, stalling while a read outpaces the engine, ignored indices and overlapping requests, and restarting after an aborted run.

// File: rtl/crb_pkg.sv
package crb_pkg;
   typedef enum logic [1:0] {
      ST_LOAD = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } crb_state_e;
endpackage

// File: rtl/crb_chal_regs.sv
// Challenge word capture: one register per word plus a mask of words
// written since the last start.
module crb_chal_regs #(
   parameter int WORD_W     = 16,
   parameter int CHAL_WORDS = 5,
   parameter int IDX_W      = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_valid,
   input  logic [IDX_W-1:0]             wr_index,
   input  logic [WORD_W-1:0]            wr_data,
   output logic [CHAL_WORDS*WORD_W-1:0] chal,
   output logic                         accept,
   output logic                         complete
);
   logic [CHAL_WORDS-1:0] mask_q;
   logic [CHAL_WORDS-1:0] sel;
   logic [CHAL_WORDS-1:0] mask_nxt;

   assign accept   = wr_valid && ({1'b0, wr_index} < (IDX_W+1)'(CHAL_WORDS));
   assign sel      = accept ? (CHAL_WORDS'(1) << wr_index) : '0;
   assign mask_nxt = mask_q | sel;
   assign complete = accept && (&mask_nxt);

   for (genvar gi = 0; gi < CHAL_WORDS; gi++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (sel[gi])
            word_q <= wr_data;
      end
      assign chal[gi*WORD_W +: WORD_W] = word_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= '0;
      else if (complete)
         mask_q <= '0;
      else if (accept)
         mask_q <= mask_nxt;
   end

   assert_mask_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      complete |=> (mask_q == '0));
endmodule

// File: rtl/crb_ct_packer.sv
// Packs engine bytes into ciphertext words and counts completed words.
module crb_ct_packer #(
   parameter int WORD_W    = 16,
   parameter int BYTE_W    = 8,
   parameter int CT_WORDS  = 138,
   parameter int CNT_W     = 8,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [CNT_W-1:0]  rd_idx,
   output logic [CNT_W-1:0]  done_words,
   output logic [WORD_W-1:0] rd_word
);
   logic [WORD_W-1:0] mem [CT_WORDS];
   logic [CNT_W-1:0]  cnt_q;
   logic              phase_q;
   logic [BYTE_W-1:0] hold_q;
   logic [WORD_W-1:0] word_new;
   logic              take;

   if (LOW_FIRST) begin : g_low_first
      assign word_new = {byte_in, hold_q};
   end else begin : g_high_first
      assign word_new = {hold_q, byte_in};
   end

   assign take = en && byte_valid && (cnt_q < CNT_W'(CT_WORDS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
         hold_q  <= '0;
      end else if (clr) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (take) begin
         if (!phase_q) begin
            hold_q  <= byte_in;
            phase_q <= 1'b1;
         end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
            phase_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!clr && take && phase_q)
         mem[cnt_q] <= word_new;
   end

   assign done_words = cnt_q;
   assign rd_word    = (rd_idx < CNT_W'(CT_WORDS)) ? mem[rd_idx] : '0;

   assert_count_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_words <= CNT_W'(CT_WORDS));
   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (done_words == $past(done_words)) ||
               (done_words == $past(done_words) + CNT_W'(1)));
endmodule

// File: rtl/crb_rd_server.sv
// Block-read sequencer: validates requests, then walks the word pointer,
// holding on words not yet complete.
module crb_rd_server #(
   parameter int CT_WORDS = 138,
   parameter int CNT_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cancel,
   input  logic             req,
   input  logic [CNT_W-1:0] offset,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] done_words,
   output logic             busy,
   output logic             err,
   output logic             data_valid,
   output logic [CNT_W-1:0] rd_idx
);
   logic [CNT_W-1:0] ptr_q;
   logic [CNT_W-1:0] rem_q;
   logic             bad;
   logic [CNT_W:0]   end_sum;

   assign end_sum    = {1'b0, offset} + {1'b0, count};
   assign bad        = (count == '0) || (end_sum > (CNT_W+1)'(CT_WORDS));
   assign data_valid = busy && (ptr_q < done_words);
   assign rd_idx     = ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         err   <= 1'b0;
         ptr_q <= '0;
         rem_q <= '0;
      end else begin
         err <= 1'b0;
         if (cancel) begin
            busy <= 1'b0;
         end else if (busy) begin
            if (data_valid) begin
               ptr_q <= ptr_q + CNT_W'(1);
               rem_q <= rem_q - CNT_W'(1);
               if (rem_q == CNT_W'(1))
                  busy <= 1'b0;
            end
         end else if (req) begin
            if (bad) begin
               err <= 1'b1;
            end else begin
               busy  <= 1'b1;
               ptr_q <= offset;
               rem_q <= count;
            end
         end
      end
   end

   assert_err_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy);
   assert_ptr_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (({1'b0, ptr_q} + {1'b0, rem_q}) <= (CNT_W+1)'(CT_WORDS)) && (rem_q != '0));
endmodule

// File: rtl/chal_resp_buf.sv
module chal_resp_buf #(
   parameter int WORD_W      = 16,
   parameter int BYTE_W      = 8,
   parameter int CHAL_WORDS  = 5,
   parameter int CT_WORDS    = 138,
   parameter bit LOW_FIRST   = 1'b1,
   localparam int IDX_W      = $clog2(CHAL_WORDS),
   localparam int CNT_W      = $clog2(CT_WORDS + 1),
   localparam int CHAL_W     = CHAL_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chal_wr,
   input  logic [IDX_W-1:0]  chal_idx,
   input  logic [WORD_W-1:0] chal_data,
   input  logic              rd_req,
   input  logic [CNT_W-1:0]  rd_offset,
   input  logic [CNT_W-1:0]  rd_count,
   output logic              rd_busy,
   output logic              rd_err,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data,
   output logic              ct_ready,
   output logic [CHAL_W-1:0] eng_chal,
   output logic              eng_start,
   output logic              eng_abort,
   input  logic              eng_byte_valid,
   input  logic [BYTE_W-1:0] eng_byte
);
   import crb_pkg::*;

   if (WORD_W != 2 * BYTE_W) begin : g_bad_width
      $error("WORD_W must hold exactly two bytes");
   end
   if (CHAL_WORDS < 2 || CT_WORDS < 1) begin : g_bad_depth
      $error("CHAL_WORDS must be at least 2 and CT_WORDS at least 1");
   end

   crb_state_e       state_q;
   logic             wr_accept;
   logic             chal_complete;
   logic [CNT_W-1:0] done_words;
   logic [CNT_W-1:0] rd_idx;

   crb_chal_regs #(
      .WORD_W(WORD_W), .CHAL_WORDS(CHAL_WORDS), .IDX_W(IDX_W)
   ) u_chal (
      .clk(clk), .rst_n(rst_n), .wr_valid(chal_wr), .wr_index(chal_idx),
      .wr_data(chal_data), .chal(eng_chal), .accept(wr_accept),
      .complete(chal_complete)
   );

   crb_ct_packer #(
      .WORD_W(WORD_W), .BYTE_W(BYTE_W), .CT_WORDS(CT_WORDS),
      .CNT_W(CNT_W), .LOW_FIRST(LOW_FIRST)
   ) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(wr_accept), .en(state_q == ST_RUN),
      .byte_valid(eng_byte_valid), .byte_in(eng_byte), .rd_idx(rd_idx),
      .done_words(done_words), .rd_word(rd_data)
   );

   crb_rd_server #(
      .CT_WORDS(CT_WORDS), .CNT_W(CNT_W)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .cancel(wr_accept), .req(rd_req),
      .offset(rd_offset), .count(rd_count), .done_words(done_words),
      .busy(rd_busy), .err(rd_err), .data_valid(rd_valid), .rd_idx(rd_idx)
   );

   assign ct_ready = (done_words == CNT_W'(CT_WORDS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_LOAD;
         eng_start <= 1'b0;
         eng_abort <= 1'b0;
      end else begin
         eng_start <= chal_complete;
         eng_abort <= wr_accept && (state_q == ST_RUN);
         if (wr_accept)
            state_q <= chal_complete ? ST_RUN : ST_LOAD;
         else if (state_q == ST_RUN && ct_ready)
            state_q <= ST_DONE;
      end
   end

   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   assert_start_fresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (state_q == ST_RUN) && (done_words == '0));
   assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |=> !eng_abort);
   assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |-> (done_words == '0) && !rd_busy && !eng_start);
endmodule

// File: tb/chal_resp_buf_bench.sv
module chal_resp_buf_bench;
   localparam int NW  = 138;
   localparam int GAP = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chal_wr = 1'b0;
   logic [2:0]  chal_idx = '0;
   logic [15:0] chal_data = '0;
   logic        rd_req = 1'b0;
   logic [7:0]  rd_offset = '0;
   logic [7:0]  rd_count = '0;
   logic        rd_busy, rd_err, rd_valid, ct_ready, eng_start, eng_abort;
   logic [15:0] rd_data;
   logic [79:0] eng_chal;
   logic        eng_byte_valid;
   logic [7:0]  eng_byte;

   int n_chk  = 0;
   int n_fail = 0;
   int n_start = 0;

   always #5 clk = ~clk;

   chal_resp_buf u_chal_resp_buf (
      .clk(clk), .rst_n(rst_n), .chal_wr(chal_wr), .chal_idx(chal_idx),
      .chal_data(chal_data), .rd_req(rd_req), .rd_offset(rd_offset),
      .rd_count(rd_count), .rd_busy(rd_busy), .rd_err(rd_err),
      .rd_valid(rd_valid), .rd_data(rd_data), .ct_ready(ct_ready),
      .eng_chal(eng_chal), .eng_start(eng_start), .eng_abort(eng_abort),
      .eng_byte_valid(eng_byte_valid), .eng_byte(eng_byte)
   );

   function automatic logic [7:0] fb(int k, logic [7:0] s);
      return 8'((k * 13 + int'(s)) ^ (k >> 3));
   endfunction

   function automatic logic [15:0] exp_word(int j, logic [79:0] c);
      logic [7:0] s;
      s = c[7:0] ^ c[79:72];
      return {fb(2 * j + 1, s), fb(2 * j, s)};
   endfunction

   // Engine model: one byte every GAP cycles, least significant first.
   logic       eng_on;
   int         bidx;
   int         gcnt;
   logic [7:0] seed;
   always @(posedge clk) begin
      if (!rst_n) begin
         eng_on <= 1'b0; bidx <= 0; gcnt <= 0; seed <= '0;
         eng_byte_valid <= 1'b0; eng_byte <= '0;
      end else begin
         eng_byte_valid <= 1'b0;
         if (eng_start) n_start <= n_start + 1;
         if (eng_abort) begin
            eng_on <= 1'b0;
         end else if (eng_start) begin
            eng_on <= 1'b1; bidx <= 0; gcnt <= 0;
            seed <= eng_chal[7:0] ^ eng_chal[79:72];
         end else if (eng_on) begin
            if (gcnt == GAP - 1) begin
               gcnt <= 0;
               eng_byte_valid <= 1'b1;
               eng_byte <= fb(bidx, seed);
               bidx <= bidx + 1;
               if (bidx == 2 * NW - 1) eng_on <= 1'b0;
            end else begin
               gcnt <= gcnt + 1;
            end
         end
      end
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr_chal(int idx, logic [15:0] d);
      @(negedge clk);
      chal_wr = 1'b1; chal_idx = 3'(idx); chal_data = d;
      @(negedge clk);
      chal_wr = 1'b0;
   endtask

   task automatic load_chal(logic [79:0] c, int upto);
      for (int i = 0; i < upto; i++) wr_chal(i, c[16*i +: 16]);
   endtask

   // Issues a read, collects the words and checks them against c.
   task automatic do_read(int off, int cnt, bit exp_err, logic [79:0] c,
                          string req, output int stalls);
      int got;
      int bad_idx;
      logic [15:0] bad_act;
      int tmo;
      stalls = 0; got = 0; bad_idx = -1; bad_act = '0; tmo = 0;
      @(negedge clk);
      rd_req = 1'b1; rd_offset = 8'(off); rd_count = 8'(cnt);
      @(negedge clk);
      rd_req = 1'b0;
      chk(rd_err == exp_err, req, $sformatf("rd_err off=%0d cnt=%0d", off, cnt),
          rd_err, exp_err);
      if (exp_err) begin
         chk(!rd_busy && !rd_valid, req, "no data after reject",
             {rd_busy, rd_valid}, 0);
         @(negedge clk);
         chk(!rd_err && !rd_busy, "R6", "reject pulse width", {rd_err, rd_busy}, 0);
      end else begin
         while (got < cnt && tmo < 5000) begin
            if (rd_valid) begin
               if (bad_idx < 0 && rd_data != exp_word(off + got, c)) begin
                  bad_idx = off + got; bad_act = rd_data;
               end
               got++;
            end else begin
               stalls++;
            end
            tmo++;
            @(negedge clk);
         end
         chk(got == cnt, req, "word count delivered", got, cnt);
         chk(bad_idx < 0, req, $sformatf("word data at %0d", bad_idx), bad_act,
             (bad_idx < 0) ? 0 : exp_word(bad_idx, c));
         chk(!rd_busy && !rd_valid, req, "stream ends", {rd_busy, rd_valid}, 0);
      end
   endtask

   task automatic wait_ready();
      int t;
      t = 0;
      while (!ct_ready && t < 3000) begin @(negedge clk); t++; end
   endtask

   localparam int NT = 9;
   localparam int T_OFF [NT] = '{0, 137, 10, 100, 0, 130, 137, 200, 5};
   localparam int T_CNT [NT] = '{1, 1, 17, 38, 0, 9, 2, 1, 128};
   localparam bit T_ERR [NT] = '{0, 0, 0, 0, 1, 1, 1, 1, 0};

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [79:0] ca, cb, cc;
      int st;
      int s0;
      ca = 80'h1357_9BDF_2468_ACE0_F00D;
      cb = 80'hA5A5_0F0F_C3C3_1234_5678;
      cc = cb; cc[47:32] = 16'hBEEF;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({rd_busy, rd_valid, rd_err, ct_ready, eng_start, eng_abort} == 6'b0,
          "R1", "outputs after reset",
          {rd_busy, rd_valid, rd_err, ct_ready, eng_start, eng_abort}, 0);

      // R2 out-of-range indices ignored
      wr_chal(5, 16'hFFFF); wr_chal(6, 16'hEEEE); wr_chal(7, 16'hDDDD);
      repeat (2) @(negedge clk);
      chk(eng_chal == 80'h0, "R2", "eng_chal after idx 5..7", eng_chal, 0);
      chk(n_start == 0, "R2", "no start from idx 5..7", n_start, 0);

      // R3 start only after the fifth word
      load_chal(ca, 4);
      @(negedge clk);
      chk(n_start == 0 && !eng_start, "R3", "no start with four words", n_start, 0);
      wr_chal(4, ca[79:64]);
      chk(eng_start == 1'b1, "R3", "start pulse after last word", eng_start, 1);
      chk(eng_chal == ca, "R2", "assembled challenge", eng_chal, ca);
      // R7 / R5 / R4: full read overlapping encryption
      do_read(0, NW, 1'b0, ca, "R7", st);
      chk(n_start == 1, "R3", "single start pulse", n_start, 1);
      chk(st > 0, "R5", "read stalled on missing words", st, 1);
      chk(ct_ready == 1'b1, "R10", "ct_ready after all words", ct_ready, 1);

      // Table of block reads after completion (R4, R5, R6)
      for (int i = 0; i < NT; i++)
         do_read(T_OFF[i], T_CNT[i], T_ERR[i], ca, T_ERR[i] ? "R6" : "R5", st);

      // R9 request while busy is ignored
      @(negedge clk);
      rd_req = 1'b1; rd_offset = 8'd0; rd_count = 8'd4;
      @(negedge clk);
      chk(rd_valid && rd_data == exp_word(0, ca), "R9", "first word", rd_data, exp_word(0, ca));
      rd_offset = 8'd50; rd_count = 8'd2;
      for (int k = 1; k < 4; k++) begin
         @(negedge clk);
         rd_req = 1'b0;
         chk(rd_valid && !rd_err && rd_data == exp_word(k, ca), "R9",
             $sformatf("word %0d kept from first request", k), rd_data, exp_word(k, ca));
      end
      @(negedge clk);
      chk(!rd_busy && !rd_valid && !rd_err, "R9", "stream ends after 4",
          {rd_busy, rd_valid, rd_err}, 0);

      // R8 abort during encryption
      load_chal(cb, 5);
      repeat (100) @(negedge clk);
      chk(!ct_ready, "R10", "not ready mid-run", ct_ready, 0);
      wr_chal(2, cc[47:32]);
      chk(eng_abort == 1'b1, "R8", "abort pulse", eng_abort, 1);
      @(negedge clk);
      chk(eng_abort == 1'b0, "R8", "abort pulse width", eng_abort, 0);
      rd_req = 1'b1; rd_offset = 8'd0; rd_count = 8'd1;
      @(negedge clk);
      rd_req = 1'b0;
      repeat (20) @(negedge clk);
      chk(rd_busy && !rd_valid, "R8", "count cleared, read stalls",
          {rd_busy, rd_valid}, 2);
      s0 = n_start;
      wr_chal(0, cc[15:0]);
      chk(!rd_busy, "R8", "challenge write cancels read", rd_busy, 0);
      wr_chal(1, cc[31:16]); wr_chal(3, cc[63:48]);
      chk(n_start == s0, "R8", "no restart with word 4 missing", n_start, s0);
      wr_chal(4, cc[79:64]);
      chk(eng_start == 1'b1, "R8", "restart after full rewrite", eng_start, 1);
      do_read(0, NW, 1'b0, cc, "R8", st);

      // R10 / R8 rewrite after completion: no abort, ready drops
      wait_ready();
      chk(ct_ready, "R10", "ready after restart", ct_ready, 1);
      wr_chal(0, 16'h0001);
      chk(!eng_abort && !ct_ready, "R10", "write after done clears ready, no abort",
          {eng_abort, ct_ready}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule